// File: doc/BRIEF.md
# Digital First-Order Delta-Sigma Modulator

This block is a clocked, all-digital first-order delta-sigma loop. It takes a signed fixed-point sample each cycle that a valid strobe is high. It turns the sample sequence into a one-bit pulse-density stream whose density of ones tracks the input relative to a programmable reference magnitude. Each active cycle does one full loop iteration. A bipolar feedback level, plus or minus the reference and chosen by the previous output bit, is taken from the input. The difference is added into a saturating integrator. The updated integrator is compared against zero to form the next bit.

A companion flag reports overload. It is set when the magnitude of the input sample reaches or passes the reference. In that condition the stream can no longer follow the input and pins to all ones or all zeros. The flag is registered on the same edge as the output bit. When the valid strobe is low, the whole loop holds: the integrator, the output bit and the flag keep their values.

Top module: `dsm_first_order`

## Requirements
- R1: A synchronous active-high reset clears the integrator to zero and drives the output bit and the overload flag to 0. The first active cycle after reset therefore uses a feedback level of minus the reference.
- R2: On each cycle with the valid strobe high, the error is the input minus the feedback level. The feedback level is plus the reference when the current output bit is 1, and minus the reference when it is 0.
- R3: On each valid cycle the integrator becomes its previous value plus the error.
- R4: On each valid cycle the output bit is registered as 1 when the updated integrator is strictly greater than zero, and as 0 otherwise, including when it is exactly zero.
- R5: The integrator is 20-bit two's complement. It saturates at +524287 and at -524288 instead of wrapping.
- R6: On each valid cycle the overload flag is registered as 1 when the absolute value of the input is greater than or equal to the reference, and as 0 otherwise.
- R7: While the valid strobe is low, the integrator, the output bit and the overload flag all hold, whatever values the input and the reference carry.
- R8: With a zero input from reset, the output alternates 1, 0, 1, 0, so any even-length run has exactly half ones.
- R9: With an input of half the reference from reset, the stream repeats 1, 1, 1, 0, a density of three quarters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Loop clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Sample strobe; the loop advances only when high |
| x_i | input | 16 | Input sample, signed two's complement |
| vref_i | input | 16 | Reference magnitude, signed two's complement, expected positive |
| bit_o | output | 1 | Pulse-density output bit |
| ovl_o | output | 1 | Registered overload flag |

## Verification
A hand-worked vector sequence with a reference of 1000 drives zero, positive, negative, exactly-at-reference and just-below-reference inputs, with gaps in the strobe. It tells apart the sign of the feedback, the strict comparison at zero, the greater-or-equal overload edge and holding on an idle strobe. Long constant runs at zero and at half the reference check the exact densities of one half and three quarters. Full-scale positive and negative runs followed by a zero input measure how many cycles the stream takes to recover. That count is 525 only if the integrator clamped and did not wrap. A reset applied in the middle of a run, followed by a zero input, shows that the first bit is formed against minus the reference.

// File: rtl/dsm_pkg.sv
`timescale 1ns/1ps
package dsm_pkg;
    localparam int DSM_IN_W  = 16;
    localparam int DSM_ACC_W = 20;

    typedef enum logic {
        FB_NEG = 1'b0,
        FB_POS = 1'b1
    } fb_pol_e;
endpackage

// File: rtl/dsm_feedback_err.sv
`timescale 1ns/1ps
module dsm_feedback_err
    import dsm_pkg::*;
#(
    parameter int IN_W = DSM_IN_W,
    localparam int ERR_W = IN_W + 2
) (
    input  logic signed [IN_W-1:0]  x_i,
    input  logic signed [IN_W-1:0]  vref_i,
    input  fb_pol_e                 pol_i,
    output logic signed [ERR_W-1:0] err_o
);
    logic signed [ERR_W-1:0] x_ext;
    logic signed [ERR_W-1:0] ref_ext;
    logic signed [ERR_W-1:0] fb_lvl;

    always_comb begin
        x_ext   = ERR_W'(x_i);
        ref_ext = ERR_W'(vref_i);
        fb_lvl  = (pol_i == FB_POS) ? ref_ext : -ref_ext;
        err_o   = x_ext - fb_lvl;
    end
endmodule

// File: rtl/dsm_integrator.sv
`timescale 1ns/1ps
module dsm_integrator #(
    parameter int ERR_W = 18,
    parameter int ACC_W = 20
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [ACC_W-1:0] acc_q_o,
    output logic signed [ACC_W-1:0] acc_d_o
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(ACC_MAX);
    localparam logic signed [SUM_W-1:0] SUM_MIN = SUM_W'(ACC_MIN);

    logic signed [SUM_W-1:0] sum;
    logic signed [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        sum   = SUM_W'(acc_q) + SUM_W'(err_i);
        acc_d = acc_q;
        if (en_i) begin
            if (sum > SUM_MAX) begin
                acc_d = ACC_MAX;
            end else if (sum < SUM_MIN) begin
                acc_d = ACC_MIN;
            end else begin
                acc_d = sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_q_o = acc_q;
    assign acc_d_o = acc_d;

    // R3: a positive error below the ceiling makes the integrator grow
    p_accum_grows_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i && !err_i[ERR_W-1] && (err_i != '0) && (acc_q != ACC_MAX)
        |=> acc_q > $past(acc_q));

    // R5: once at the ceiling, a non-negative error keeps it there
    p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i && (acc_q == ACC_MAX) && !err_i[ERR_W-1]
        |=> acc_q == ACC_MAX);

    // R5: once at the floor, a negative error keeps it there
    p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i && (acc_q == ACC_MIN) && err_i[ERR_W-1]
        |=> acc_q == ACC_MIN);
endmodule

// File: rtl/dsm_overload_det.sv
`timescale 1ns/1ps
module dsm_overload_det
    import dsm_pkg::*;
#(
    parameter int IN_W = DSM_IN_W
) (
    input  logic signed [IN_W-1:0] x_i,
    input  logic signed [IN_W-1:0] vref_i,
    output logic                   ovl_o
);
    localparam int MAG_W = IN_W + 2;

    logic signed [MAG_W-1:0] x_ext;
    logic signed [MAG_W-1:0] mag;
    logic signed [MAG_W-1:0] ref_ext;

    always_comb begin
        x_ext   = MAG_W'(x_i);
        mag     = x_i[IN_W-1] ? -x_ext : x_ext;
        ref_ext = MAG_W'(vref_i);
        ovl_o   = (mag >= ref_ext);
    end
endmodule

// File: rtl/dsm_first_order.sv
`timescale 1ns/1ps
module dsm_first_order
    import dsm_pkg::*;
#(
    parameter int IN_W  = DSM_IN_W,
    parameter int ACC_W = DSM_ACC_W
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   valid_i,
    input  logic signed [IN_W-1:0] x_i,
    input  logic signed [IN_W-1:0] vref_i,
    output logic                   bit_o,
    output logic                   ovl_o
);
    localparam int ERR_W = IN_W + 2;
    localparam logic signed [ACC_W-1:0] ACC_ZERO = '0;

    typedef struct packed {
        logic bit_v;
        logic ovl;
    } loop_st_t;

    loop_st_t st_d, st_q;
    fb_pol_e  pol;
    logic signed [ERR_W-1:0] err;
    logic signed [ACC_W-1:0] acc_q, acc_d;
    logic ovl_now;

    assign pol = st_q.bit_v ? FB_POS : FB_NEG;

    dsm_feedback_err #(.IN_W(IN_W)) u_fb (
        .x_i    (x_i),
        .vref_i (vref_i),
        .pol_i  (pol),
        .err_o  (err)
    );

    dsm_integrator #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_acc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (valid_i),
        .err_i   (err),
        .acc_q_o (acc_q),
        .acc_d_o (acc_d)
    );

    dsm_overload_det #(.IN_W(IN_W)) u_ovl (
        .x_i    (x_i),
        .vref_i (vref_i),
        .ovl_o  (ovl_now)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            st_d.bit_v = (acc_d > ACC_ZERO);
            st_d.ovl   = ovl_now;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.bit_v;
    assign ovl_o = st_q.ovl;

    // R7: an idle strobe freezes both outputs
    p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> $stable(bit_o) && $stable(ovl_o));

    // R4: the output bit agrees with the sign of the integrator it was taken from
    p_cmp_sign_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> bit_o == (acc_q > ACC_ZERO));

    // R6: an input at or above a positive reference raises the flag
    p_ovl_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i && !vref_i[IN_W-1] && (x_i >= vref_i) |=> ovl_o);
endmodule

// File: tb/dsm_first_order_tb_top.sv
`timescale 1ns/1ps
module dsm_first_order_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic valid;
    logic signed [15:0] x;
    logic signed [15:0] vref;
    logic bit_w, ovl_w;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dsm_first_order dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .valid_i (valid),
        .x_i     (x),
        .vref_i  (vref),
        .bit_o   (bit_w),
        .ovl_o   (ovl_w)
    );

    // entry: {valid, x, vref, expected bit, expected flag}
    localparam int NV = 14;
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 16'sd0,     16'sd1000, 1'b1, 1'b0},
        {1'b1, 16'sd0,     16'sd1000, 1'b0, 1'b0},
        {1'b0, 16'sd700,   16'sd1000, 1'b0, 1'b0},
        {1'b1, 16'sd500,   16'sd1000, 1'b1, 1'b0},
        {1'b1, 16'sd500,   16'sd1000, 1'b1, 1'b0},
        {1'b1, 16'sd500,   16'sd1000, 1'b1, 1'b0},
        {1'b1, 16'sd500,   16'sd1000, 1'b0, 1'b0},
        {1'b1, -16'sd300,  16'sd1000, 1'b1, 1'b0},
        {1'b1, -16'sd300,  16'sd1000, 1'b0, 1'b0},
        {1'b1, 16'sd1000,  16'sd1000, 1'b1, 1'b1},
        {1'b1, -16'sd1000, 16'sd1000, 1'b0, 1'b1},
        {1'b1, 16'sd999,   16'sd1000, 1'b1, 1'b0},
        {1'b0, 16'sd5000,  16'sd1000, 1'b1, 1'b0},
        {1'b1, 16'sd0,     16'sd200,  1'b1, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic signed [15:0] xv,
                        input logic signed [15:0] rv);
        @(negedge clk);
        valid = v;
        x     = xv;
        vref  = rv;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #600000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int ones;
        int cyc;
        rst = 1'b1; valid = 1'b0; x = '0; vref = 16'sd1000;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset bit", int'(bit_w), 0);
        chk("R1 reset flag", int'(ovl_w), 0);
        @(negedge clk);
        rst = 1'b0;

        // vector walk: R2 R3 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][34], VEC[i][33:18], VEC[i][17:2]);
            chk($sformatf("R2/R4 vector %0d bit", i), int'(bit_w), int'(VEC[i][1]));
            chk($sformatf("R6/R7 vector %0d flag", i), int'(ovl_w), int'(VEC[i][0]));
        end

        // R1: reset mid-run, first bit formed against minus the reference
        step(1'b1, 16'sd32000, 16'sd1000);
        do_reset();
        #1;
        chk("R1 mid-run reset bit", int'(bit_w), 0);
        chk("R1 mid-run reset flag", int'(ovl_w), 0);
        step(1'b1, 16'sd0, 16'sd1000);
        chk("R1 first bit uses minus reference", int'(bit_w), 1);

        // R8: zero input density
        do_reset();
        ones = 0;
        for (int i = 0; i < 64; i++) begin
            step(1'b1, 16'sd0, 16'sd777);
            ones += int'(bit_w);
        end
        chk("R8 ones in 64 at zero input", ones, 32);

        // R9: half-reference density
        do_reset();
        ones = 0;
        for (int i = 0; i < 400; i++) begin
            step(1'b1, 16'sd500, 16'sd1000);
            ones += int'(bit_w);
        end
        chk("R9 ones in 400 at half reference", ones, 300);

        // R5: positive clamp, then recovery time
        do_reset();
        ones = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 16'sd32767, 16'sd1000);
            ones += int'(bit_w);
        end
        chk("R5 pinned high bits", ones, 40);
        chk("R6 flag at full scale", int'(ovl_w), 1);
        cyc = 0;
        for (int i = 1; i <= 600; i++) begin
            step(1'b1, 16'sd0, 16'sd1000);
            if (cyc == 0 && bit_w == 1'b0) cyc = i;
        end
        chk("R5 recovery from ceiling", cyc, 525);

        // R5: negative clamp, then recovery time
        do_reset();
        ones = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, -16'sd32768, 16'sd1000);
            ones += int'(bit_w);
        end
        chk("R5 pinned low bits", ones, 0);
        chk("R6 flag at negative full scale", int'(ovl_w), 1);
        cyc = 0;
        for (int i = 1; i <= 600; i++) begin
            step(1'b1, 16'sd0, 16'sd1000);
            if (cyc == 0 && bit_w == 1'b1) cyc = i;
        end
        chk("R5 recovery from floor", cyc, 525);

        // R7: idle strobe with overload-level input leaves outputs alone
        do_reset();
        step(1'b1, 16'sd0, 16'sd1000);
        step(1'b0, -16'sd32768, 16'sd10);
        chk("R7 idle bit held", int'(bit_w), 1);
        chk("R7 idle flag held", int'(ovl_w), 0);
        step(1'b1, 16'sd0, 16'sd1000);
        chk("R7 integrator held across idle", int'(bit_w), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule